// File: doc/BRIEF.md
# Public-Key Accelerator Command and Status Front-End

This block sits between a simple register bus and a public-key arithmetic engine. Software programs an operation code and an enable through a control word, and starts the engine with a self-clearing start bit. The block checks every opcode against a legal list, and against a single permitted opcode when the restricted configuration is active. It then either issues a start pulse to the engine or runs a short abort sequence. Busy status, a latched random-source readiness bit, the restricted-mode indication and four sticky event flags are shown in a status word.

The flags are cleared by writing ones to a separate clear word. One interrupt line is the OR of each flag gated by its own enable. The engine and its operand memory are outside the block. Toward the engine it has only a start pulse with the opcode, and three event pulses coming back: done, memory fault and address fault.

Top module: `pkx_front`

## Requirements
- R1: After reset the control word (byte offset 0) and the status word (offset 4) read as zero, and `irq` is 0.
- R2: A control write with bit 0 (enable) = 1 and bit 1 (start) = 1, while not busy and with a legal opcode in bits 13:8, drives `eng_start` high for exactly one cycle after the write, with `eng_opcode` equal to that opcode. Status bit 16 (busy) reads 1 from that cycle on. Control bit 1 always reads 0.
- R3: An `eng_done` pulse during a running operation clears busy and sets status bit 17 (end-of-operation flag) at the same clock edge.
- R4: A start request while busy is 1 produces no `eng_start` pulse and does not change busy.
- R5: A control write with enable = 1 whose opcode is not in the legal list leaves the stored opcode unchanged and sets status bit 21 (operation-error flag). A write with enable = 0 stores any opcode without a check.
- R6: The restricted-mode flag (status bit 1) is loaded from `cfg_limited` on every control write with enable = 1. While that flag is in effect, only opcode 0x26 is accepted. Any other opcode is rejected as in R5.
- R7: A start with an illegal stored opcode gives no `eng_start`. Busy stays high for exactly 3 cycles, then returns to 0 with bit 21 set and bit 17 not set.
- R8: Flags in status bits 17, 19, 20 and 21 are sticky. Writing 1 to the same bit of the clear word (offset 8) clears only that flag. A set event in the same cycle as a clear leaves the flag at 1.
- R9: Status bit 0 stays 0 until `rng_init_done` is seen high, and then stays 1.
- R10: `irq` is 1 exactly when some flag is 1 and its enable bit is 1 in the control word. Enables sit at the same bit positions as the flags: 17, 19, 20 and 21.
- R11: An `eng_ram_err` pulse sets status bit 19, and an `eng_addr_err` pulse sets status bit 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW (4) | Byte address of the register word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cfg_limited | input | 1 | Restricted-configuration strap, sampled on enable writes |
| rng_init_done | input | 1 | Random source ready indication |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_opcode | output | 6 | Opcode of the started operation |
| eng_done | input | 1 | Engine completion pulse |
| eng_ram_err | input | 1 | Engine operand memory fault pulse |
| eng_addr_err | input | 1 | Engine address fault pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume a well-behaved engine. It pulses `eng_done` only while an operation it was started on is running, never in the same cycle as a start, and the bus holds reset low for more than one cycle before the first access. The bench drives the engine stub to honour this. A done pulse is issued only after the start pulse has been observed, and bus writes and engine pulses are applied one cycle at a time at the falling edge. The error pulses may arrive at any time, and this includes the cycle of a clear write, which the bench uses on purpose.

// File: rtl/pkx_pkg.sv
// Shared constants and types for the accelerator front-end.
// Assumes a 32-bit register bus with word-aligned byte offsets.
package pkx_pkg;
    localparam int DW       = 32;
    localparam int OPW      = 6;
    localparam int NFLAG    = 4;
    localparam int OFF_CTRL = 0;
    localparam int OFF_STAT = 4;
    localparam int OFF_CLR  = 8;
    localparam int B_EN     = 0;
    localparam int B_GO     = 1;
    localparam int B_OPLO   = 8;
    localparam int B_INIT   = 0;
    localparam int B_LIM    = 1;
    localparam int B_BUSY   = 16;
    // flag index order: done, memory fault, address fault, opcode fault
    localparam int FI_DONE  = 0;
    localparam int FI_RAM   = 1;
    localparam int FI_ADDR  = 2;
    localparam int FI_OPER  = 3;

    typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_ABORT} sq_state_e;

    // bit position of flag i in status, clear and enable fields
    function automatic int flag_pos(input int i);
        return (i == 0) ? 17 : 18 + i;
    endfunction
endpackage

// File: rtl/pkx_opcheck.sv
// Opcode legality check. Purely combinational.
// An opcode is legal if it matches an entry of LEGAL_OPS, or, when
// restricted mode is in effect, only if it equals LIMITED_OP.
module pkx_opcheck #(
    parameter int OPW = 6,
    parameter int NUM_OPS = 8,
    parameter logic [NUM_OPS*OPW-1:0] LEGAL_OPS = '0,
    parameter logic [OPW-1:0] LIMITED_OP = '0
) (
    input  logic [OPW-1:0] op_i,
    input  logic           limited_i,
    output logic           ok_o
);
    logic [NUM_OPS-1:0] hit;

    // one comparator per legal list entry
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_cmp
        assign hit[i] = (op_i == LEGAL_OPS[i*OPW +: OPW]);
    end

    // restricted mode narrows the set to a single opcode
    always_comb ok_o = limited_i ? (op_i == LIMITED_OP) : (|hit);
endmodule

// File: rtl/pkx_seq.sv
// Start/busy/done sequencer. Accepts a go request only when idle.
// A legal request issues a one-cycle start pulse and waits for done.
// An illegal request stays busy for ABORT_CYC cycles, then aborts.
// Assumes done_i is only pulsed by the engine while it is running.
module pkx_seq
    import pkx_pkg::*;
#(
    parameter int OPW = 6,
    parameter int ABORT_CYC = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go_i,
    input  logic           op_ok_i,
    input  logic [OPW-1:0] op_i,
    input  logic           done_i,
    output logic           busy_o,
    output logic           start_o,
    output logic [OPW-1:0] opcode_o,
    output logic           done_evt_o,
    output logic           abort_evt_o
);
    localparam int CNT_W = $clog2(ABORT_CYC + 1);

    sq_state_e        state;
    logic [CNT_W-1:0] cnt;

    // state machine, abort counter and engine start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            cnt      <= '0;
            start_o  <= 1'b0;
            opcode_o <= '0;
        end else begin
            start_o <= 1'b0;
            case (state)
                SQ_IDLE: if (go_i) begin
                    opcode_o <= op_i;
                    if (op_ok_i) begin
                        state   <= SQ_RUN;
                        start_o <= 1'b1;
                    end else begin
                        state <= SQ_ABORT;
                        cnt   <= CNT_W'(ABORT_CYC - 1);
                    end
                end
                SQ_RUN:   if (done_i) state <= SQ_IDLE;
                SQ_ABORT: if (cnt == '0) state <= SQ_IDLE;
                          else cnt <= cnt - 1'b1;
                default:  state <= SQ_IDLE;
            endcase
        end
    end

    // status and event outputs
    always_comb begin
        busy_o      = (state != SQ_IDLE);
        done_evt_o  = (state == SQ_RUN) && done_i;
        abort_evt_o = (state == SQ_ABORT) && (cnt == '0);
    end

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    // R4
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (busy_o && !$past(busy_o)));
    // R7
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_ABORT) |-> !start_o);
    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt_o |=> !busy_o);
endmodule

// File: rtl/pkx_flags.sv
// Bank of sticky event flags with write-one-to-clear.
// A set in the same cycle as a clear wins.
module pkx_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar k = 0; k < N; k++) begin : g_flag
        // one sticky bit, set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)        q_o[k] <= 1'b0;
            else if (set_i[k]) q_o[k] <= 1'b1;
            else if (clr_i[k]) q_o[k] <= 1'b0;
        end

        // R8
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> q_o[k]);
        // R8
        flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !q_o[k]);
        // R8
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[k] && !set_i[k]) |=> $stable(q_o[k]));
    end
endmodule

// File: rtl/pkx_front.sv
// Register front-end for a public-key accelerator: control, status
// and clear words, opcode checking, start sequencing and interrupt.
// Assumes one-cycle write strobes and a combinational read path.
module pkx_front
    import pkx_pkg::*;
#(
    parameter int AW = 4,
    parameter int NUM_OPS = 8,
    parameter logic [NUM_OPS*6-1:0] LEGAL_OPS =
        {6'h26, 6'h20, 6'h0E, 6'h08, 6'h07, 6'h02, 6'h01, 6'h00},
    parameter logic [5:0] LIMITED_OP = 6'h26,
    parameter int ABORT_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          cfg_limited,
    input  logic          rng_init_done,
    output logic          eng_start,
    output logic [5:0]    eng_opcode,
    input  logic          eng_done,
    input  logic          eng_ram_err,
    input  logic          eng_addr_err,
    output logic          irq
);
    logic             en_q, lim_q, init_q;
    logic [OPW-1:0]   mode_q, mode_next, wr_mode;
    logic [NFLAG-1:0] ie_q, fset, fclr, fq;
    logic             ctrl_wr, clr_wr, wr_en, lim_eff;
    logic             wr_ok, go_ok, wr_reject, go;
    logic             busy, done_evt, abort_evt;
    logic             unused_wdata;

    // bus decode and write-time opcode selection
    always_comb begin
        ctrl_wr   = bus_wr && (bus_addr == AW'(OFF_CTRL));
        clr_wr    = bus_wr && (bus_addr == AW'(OFF_CLR));
        wr_en     = bus_wdata[B_EN];
        wr_mode   = bus_wdata[B_OPLO +: OPW];
        lim_eff   = wr_en ? cfg_limited : lim_q;
        wr_reject = ctrl_wr && wr_en && !wr_ok;
        mode_next = (ctrl_wr && !wr_reject) ? wr_mode : mode_q;
        go        = ctrl_wr && wr_en && bus_wdata[B_GO];
    end

    assign unused_wdata = ^{bus_wdata[31:22], bus_wdata[18],
                            bus_wdata[16:14], bus_wdata[7:2]};

    // check of an opcode being written
    pkx_opcheck #(.OPW(OPW), .NUM_OPS(NUM_OPS), .LEGAL_OPS(LEGAL_OPS),
                  .LIMITED_OP(LIMITED_OP)) u_wrchk (
        .op_i(wr_mode), .limited_i(lim_eff), .ok_o(wr_ok));

    // check of the opcode a start would launch
    pkx_opcheck #(.OPW(OPW), .NUM_OPS(NUM_OPS), .LEGAL_OPS(LEGAL_OPS),
                  .LIMITED_OP(LIMITED_OP)) u_gochk (
        .op_i(mode_next), .limited_i(lim_eff), .ok_o(go_ok));

    pkx_seq #(.OPW(OPW), .ABORT_CYC(ABORT_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .go_i(go), .op_ok_i(go_ok),
        .op_i(mode_next), .done_i(eng_done), .busy_o(busy),
        .start_o(eng_start), .opcode_o(eng_opcode),
        .done_evt_o(done_evt), .abort_evt_o(abort_evt));

    // flag set and clear sources
    always_comb begin
        fset[FI_DONE] = done_evt;
        fset[FI_RAM]  = eng_ram_err;
        fset[FI_ADDR] = eng_addr_err;
        fset[FI_OPER] = wr_reject || abort_evt;
        for (int k = 0; k < NFLAG; k++)
            fclr[k] = clr_wr && bus_wdata[flag_pos(k)];
    end

    pkx_flags #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(fset), .clr_i(fclr), .q_o(fq));

    // control word fields and restricted-mode sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= '0;
            ie_q   <= '0;
            lim_q  <= 1'b0;
        end else if (ctrl_wr) begin
            en_q   <= wr_en;
            mode_q <= mode_next;
            for (int k = 0; k < NFLAG; k++) ie_q[k] <= bus_wdata[flag_pos(k)];
            if (wr_en) lim_q <= cfg_limited;
        end
    end

    // readiness of the random source, latched
    always_ff @(posedge clk) begin
        if (!rst_n)             init_q <= 1'b0;
        else if (rng_init_done) init_q <= 1'b1;
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFF_CTRL): begin
                bus_rdata[B_EN]          = en_q;
                bus_rdata[B_OPLO +: OPW] = mode_q;
                for (int k = 0; k < NFLAG; k++) bus_rdata[flag_pos(k)] = ie_q[k];
            end
            AW'(OFF_STAT): begin
                bus_rdata[B_INIT] = init_q;
                bus_rdata[B_LIM]  = lim_q;
                bus_rdata[B_BUSY] = busy;
                for (int k = 0; k < NFLAG; k++) bus_rdata[flag_pos(k)] = fq[k];
            end
            default: bus_rdata = '0;
        endcase
    end

    // combined interrupt
    always_comb irq = |(fq & ie_q);

    // R9
    init_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_q) |-> $past(rng_init_done));
    // R5
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |=> ($stable(mode_q) && fq[FI_OPER]));
    // R7
    abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> (!busy && fq[FI_OPER]));
endmodule

// File: tb/sim_pkx_front.sv
`timescale 1ns/1ps
module sim_pkx_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cfg_limited = 1'b0;
    logic        rng_init_done = 1'b0;
    logic        eng_start;
    logic [5:0]  eng_opcode;
    logic        eng_done = 1'b0;
    logic        eng_ram_err = 1'b0;
    logic        eng_addr_err = 1'b0;
    logic        irq;

    int nchk = 0;
    int nerr = 0;
    int starts = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pkx_front u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_limited(cfg_limited),
        .rng_init_done(rng_init_done), .eng_start(eng_start),
        .eng_opcode(eng_opcode), .eng_done(eng_done),
        .eng_ram_err(eng_ram_err), .eng_addr_err(eng_addr_err), .irq(irq));

    // count engine start pulses, one falling edge per pulse cycle
    always @(negedge clk) if (rst_n && eng_start) starts++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic expect_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    function automatic logic [31:0] cw(input bit en, input bit go,
                                       input logic [5:0] op, input logic [3:0] ie);
        logic [31:0] w = '0;
        w[0] = en; w[1] = go; w[13:8] = op;
        w[17] = ie[0]; w[19] = ie[1]; w[20] = ie[2]; w[21] = ie[3];
        return w;
    endfunction

    // all tasks start just after a falling edge and end just after one
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic clear_all();
        wr(4'd8, 32'h003A_0000);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd0, d); expect_eq("R1 ctrl", d, 0);
        rd(4'd4, d); expect_eq("R1 status", d, 0);
        expect_eq("R1 irq", irq, 0);
    endtask

    task automatic t_init();
        logic [31:0] d;
        @(negedge clk);
        rd(4'd4, d); expect_eq("R9 init before", d[0], 0);
        rng_init_done = 1'b1;
        @(negedge clk);
        rng_init_done = 1'b0;
        @(negedge clk);
        rd(4'd4, d); expect_eq("R9 init latched", d[0], 1);
    endtask

    task automatic t_mode_write();
        logic [31:0] d;
        wr(4'd0, cw(1, 0, 6'h07, 4'h0));
        rd(4'd0, d); expect_eq("R5 legal stored", d[13:8], 7);
        wr(4'd0, cw(1, 0, 6'h15, 4'h0));
        rd(4'd0, d); expect_eq("R5 illegal kept", d[13:8], 7);
        rd(4'd4, d); expect_eq("R5 operr set", d[21], 1);
        clear_all();
        wr(4'd0, cw(0, 0, 6'h15, 4'h0));
        rd(4'd0, d); expect_eq("R5 unchecked when disabled", d[13:8], 6'h15);
        rd(4'd4, d); expect_eq("R5 no operr when disabled", d[21], 0);
    endtask

    task automatic t_start_ok();
        logic [31:0] d;
        int s0;
        s0 = starts;
        wr(4'd0, cw(1, 1, 6'h08, 4'h0));
        expect_eq("R2 start pulse", eng_start, 1);
        expect_eq("R2 opcode", eng_opcode, 8);
        rd(4'd4, d); expect_eq("R2 busy", d[16], 1);
        rd(4'd0, d); expect_eq("R2 start reads 0", d[1], 0);
        @(negedge clk);
        expect_eq("R2 single pulse", starts - s0, 1);
        wr(4'd0, cw(1, 1, 6'h08, 4'h0));
        @(negedge clk);
        expect_eq("R4 no restart", starts - s0, 1);
        rd(4'd4, d); expect_eq("R4 still busy", d[16], 1);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        rd(4'd4, d);
        expect_eq("R3 busy cleared", d[16], 0);
        expect_eq("R3 done flag", d[17], 1);
    endtask

    task automatic t_bad_start();
        logic [31:0] d;
        int s0;
        clear_all();
        wr(4'd0, cw(0, 0, 6'h15, 4'h0));
        s0 = starts;
        wr(4'd0, cw(1, 1, 6'h15, 4'h0));
        rd(4'd4, d); expect_eq("R7 busy c1", d[16], 1);
        wr(4'd8, 32'h0020_0000);
        rd(4'd4, d);
        expect_eq("R7 busy c2", d[16], 1);
        expect_eq("R7 operr not yet", d[21], 0);
        @(negedge clk);
        rd(4'd4, d); expect_eq("R7 busy c3", d[16], 1);
        @(negedge clk);
        rd(4'd4, d);
        expect_eq("R7 busy released", d[16], 0);
        expect_eq("R7 operr after abort", d[21], 1);
        expect_eq("R7 no done flag", d[17], 0);
        expect_eq("R7 no start pulse", starts - s0, 0);
    endtask

    task automatic t_limited();
        logic [31:0] d;
        clear_all();
        cfg_limited = 1'b1;
        wr(4'd0, cw(1, 0, 6'h26, 4'h0));
        rd(4'd0, d); expect_eq("R6 0x26 accepted", d[13:8], 6'h26);
        rd(4'd4, d); expect_eq("R6 flag sampled", d[1], 1);
        wr(4'd0, cw(1, 0, 6'h07, 4'h0));
        rd(4'd0, d); expect_eq("R6 other rejected", d[13:8], 6'h26);
        rd(4'd4, d); expect_eq("R6 operr", d[21], 1);
        cfg_limited = 1'b0;
        clear_all();
        wr(4'd0, cw(1, 0, 6'h07, 4'h0));
        rd(4'd0, d); expect_eq("R6 full set again", d[13:8], 7);
        rd(4'd4, d); expect_eq("R6 flag resampled", d[1], 0);
    endtask

    task automatic t_errors();
        logic [31:0] d;
        clear_all();
        eng_ram_err = 1'b1; @(negedge clk); eng_ram_err = 1'b0;
        eng_addr_err = 1'b1; @(negedge clk); eng_addr_err = 1'b0;
        rd(4'd4, d);
        expect_eq("R11 ram flag", d[19], 1);
        expect_eq("R11 addr flag", d[20], 1);
        @(negedge clk);
        rd(4'd4, d); expect_eq("R8 sticky", d[20:19], 3);
        wr(4'd8, 32'h0008_0000);
        rd(4'd4, d); expect_eq("R8 clear one only", d[20:19], 2);
        eng_ram_err = 1'b1;
        wr(4'd8, 32'h0008_0000);
        eng_ram_err = 1'b0;
        rd(4'd4, d); expect_eq("R8 set wins", d[19], 1);
    endtask

    task automatic t_irq();
        clear_all();
        eng_addr_err = 1'b1; @(negedge clk); eng_addr_err = 1'b0;
        wr(4'd0, cw(0, 0, 6'h07, 4'h0));
        expect_eq("R10 masked", irq, 0);
        wr(4'd0, cw(0, 0, 6'h07, 4'h4));
        expect_eq("R10 enabled", irq, 1);
        wr(4'd0, cw(0, 0, 6'h07, 4'hB));
        expect_eq("R10 other enables", irq, 0);
        wr(4'd8, 32'h0010_0000);
        wr(4'd0, cw(0, 0, 6'h07, 4'h4));
        expect_eq("R10 cleared flag", irq, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init();
        t_mode_write();
        t_start_ok();
        t_bad_start();
        t_limited();
        t_errors();
        t_irq();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule